// File: doc/BRIEF.md
# Sample-Ready Status and Interrupt Router

This block sits between a three-axis sampling front end and the register file of a motion sensor. Each axis delivers new samples as a one-cycle valid strobe with its data word. The block keeps a ready flag and an overrun flag for every axis. It publishes an eight-bit status byte that also carries two summary bits. It holds the output words that software reads byte by byte. When the block-update rule is enabled, a word already in the output stays frozen until both of its bytes have been read, so a reader never mixes the halves of two samples.

Sample input is a valid-only stream: the block accepts every sample in the cycle it is offered and never applies back-pressure. There is therefore no ready signal. A sample that arrives while the word in the output is still frozen is parked in a one-deep slot per axis. A newer sample replaces the parked one.

Two interrupt pins report the OR of a per-pin selection of event flags: all-axes ready, boot in progress, FIFO overrun, FIFO full and FIFO threshold. The ready indication on pin 1 can be a level or a pulse lasting one quarter of the output-data-rate period. Each pin can be push-pull or open-drain. Pin 1 can also be turned into an input whose level is passed on as the FIFO trigger.

Top module: `drdy_irq_router`

## Requirements
- R1: The status byte is, from bit 7 down to bit 0: any-overrun, Z overrun, Y overrun, X overrun, all-ready, Z ready, Y ready, X ready. Axis index 0 is X, 1 is Y, 2 is Z. In `smp_data` and `out_word`, axis k occupies bits [k*DW +: DW].
- R2: Status bit 3 is the AND of bits 2..0, and status bit 7 is the OR of bits 6..4.
- R3: A valid sample on an axis whose ready bit is set, when that axis's high byte is not read in the same cycle, sets that axis's overrun bit. Both bits are visible the cycle after the strobe.
- R4: A high-byte read strobe on an axis, with no sample arriving on that axis in the same cycle, clears that axis's ready and overrun bits on the next cycle.
- R5: With the block-update rule off (`bdu_en`=0), the output word of an axis takes each valid sample on the cycle after its strobe.
- R6: With the block-update rule on, an output word already loaded is held until both its low and high byte reads have been seen. The newest sample that arrived meanwhile is loaded on the same edge as the completing read.
- R7: With `drdy_pulse_sel`=0, the ready source of pin 1 follows the all-ready status bit as a level.
- R8: With `drdy_pulse_sel`=1, a rise of the all-ready bit produces a pin-1 ready pulse of exactly ODR_CYC/4 clock cycles, beginning one cycle after the rise.
- R9: Each pin is active when any enabled source is set. The enable bit order is 0 ready, 1 boot, 2 FIFO overrun, 3 FIFO full, 4 FIFO threshold.
- R10: In push-pull mode a pin drives its active state high with the output enable held at 1. In open-drain mode the data output is 0 and the output enable equals the active state, so the pin only pulls low.
- R11: With `int1_as_input`=1, pin 1 never drives (`int1_oe`=0, `int1_o`=0), and `fifo_trig` follows `int1_pad_i`. Otherwise `fifo_trig` is 0.
- R12: Pin 2 always uses the all-ready level as its ready source, whatever the pulse selection.
- R13: After reset the status byte and the output words are zero, and no ready pulse is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 3 | Per-axis new-sample strobe (bit 0 X) |
| smp_data | input | 3*DW | Per-axis sample words |
| rd_lo | input | 3 | Per-axis low output byte read strobe |
| rd_hi | input | 3 | Per-axis high output byte read strobe |
| bdu_en | input | 1 | Block-update rule enable |
| drdy_pulse_sel | input | 1 | 0: level ready on pin 1, 1: pulsed |
| int1_en | input | 5 | Pin 1 source enables |
| int2_en | input | 5 | Pin 2 source enables |
| int1_od | input | 1 | Pin 1 open-drain select |
| int2_od | input | 1 | Pin 2 open-drain select |
| int1_as_input | input | 1 | Pin 1 becomes the FIFO trigger input |
| int1_pad_i | input | 1 | Level sensed on pin 1 |
| boot_busy | input | 1 | Boot in progress flag |
| fifo_ovr | input | 1 | FIFO overrun flag |
| fifo_full | input | 1 | FIFO full flag (count bit 5) |
| fifo_fth | input | 1 | FIFO threshold flag |
| status | output | 8 | Status byte |
| out_word | output | 3*DW | Held output words |
| int1_o | output | 1 | Pin 1 data drive |
| int1_oe | output | 1 | Pin 1 output enable |
| int2_o | output | 1 | Pin 2 data drive |
| int2_oe | output | 1 | Pin 2 output enable |
| fifo_trig | output | 1 | Trigger level passed from pin 1 |

## Verification
The main tracking function is driven with axes arriving one at a time and all together, which separates the per-axis bits from the AND and OR summary bits. Repeating a sample before its high byte is read distinguishes overrun from plain ready. The same sample sequence is applied with the block-update rule off and on. This shows whether the output word follows every strobe or freezes until both byte reads, and whether the newest parked sample is the one loaded. Interrupt routing is tried with one flag source active at a time. That exposes any swap in the enable order, the push-pull and open-drain drive, and the input use of pin 1.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  localparam int NAXES = 3;
  localparam int NSRC  = 5;
  localparam int NPINS = 2;

  // source index inside a pin enable vector
  localparam int SRC_RDY  = 0;
  localparam int SRC_BOOT = 1;
  localparam int SRC_OVR  = 2;
  localparam int SRC_FULL = 3;
  localparam int SRC_FTH  = 4;

  typedef struct packed {
    logic             ovr_any;
    logic [NAXES-1:0] ovr;
    logic             rdy_all;
    logic [NAXES-1:0] rdy;
  } stat_t;
endpackage

// File: rtl/drdy_axis_hold.sv
module drdy_axis_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [DW-1:0] data,
  input  logic          rd_lo,
  input  logic          rd_hi,
  input  logic          bdu_en,
  output logic          rdy,
  output logic          ovr,
  output logic [DW-1:0] word
);
  logic          lo_seen, hi_seen;
  logic          pend_v;
  logic [DW-1:0] pend;
  logic          free_now, free_next;

  assign free_now  = lo_seen & hi_seen;
  assign free_next = (lo_seen | rd_lo) & (hi_seen | rd_hi);

  // ready and overrun flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end else if (valid) begin
      rdy <= 1'b1;
      ovr <= rd_hi ? 1'b0 : (ovr | rdy);
    end else if (rd_hi) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end
  end

  // output word with optional block-update hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      pend    <= '0;
      pend_v  <= 1'b0;
      lo_seen <= 1'b1;
      hi_seen <= 1'b1;
    end else if (valid && (!bdu_en || free_now)) begin
      word    <= data;
      pend_v  <= 1'b0;
      lo_seen <= 1'b0;
      hi_seen <= 1'b0;
    end else if (valid) begin
      pend    <= data;
      pend_v  <= 1'b1;
      lo_seen <= lo_seen | rd_lo;
      hi_seen <= hi_seen | rd_hi;
    end else if (pend_v && (!bdu_en || free_next)) begin
      word    <= pend;
      pend_v  <= 1'b0;
      lo_seen <= 1'b0;
      hi_seen <= 1'b0;
    end else begin
      lo_seen <= lo_seen | rd_lo;
      hi_seen <= hi_seen | rd_hi;
    end
  end
endmodule

// File: rtl/drdy_shaper.sv
module drdy_shaper #(
  parameter int PW = 100,
  parameter int CW = $clog2(PW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic pulse_sel,
  output logic shaped
);
  logic          level_d;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_d <= 1'b0;
      cnt     <= '0;
    end else begin
      level_d <= level;
      if (level && !level_d)
        cnt <= CW'(PW);
      else if (cnt != '0)
        cnt <= cnt - CW'(1);
    end
  end

  assign shaped = pulse_sel ? (cnt != '0) : level;
endmodule

// File: rtl/drdy_irq_pin.sv
module drdy_irq_pin
  import drdy_pkg::*;
(
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] en,
  input  logic            od,
  input  logic            as_input,
  output logic            pin_o,
  output logic            pin_oe
);
  logic active;

  assign active = |(flags & en);

  always_comb begin
    if (as_input) begin
      pin_o  = 1'b0;
      pin_oe = 1'b0;
    end else if (od) begin
      pin_o  = 1'b0;
      pin_oe = active;
    end else begin
      pin_o  = active;
      pin_oe = 1'b1;
    end
  end
endmodule

// File: rtl/drdy_irq_router.sv
module drdy_irq_router
  import drdy_pkg::*;
#(
  parameter int DW      = 16,
  parameter int ODR_CYC = 400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NAXES-1:0]    smp_valid,
  input  logic [NAXES*DW-1:0] smp_data,
  input  logic [NAXES-1:0]    rd_lo,
  input  logic [NAXES-1:0]    rd_hi,
  input  logic                bdu_en,
  input  logic                drdy_pulse_sel,
  input  logic [NSRC-1:0]     int1_en,
  input  logic [NSRC-1:0]     int2_en,
  input  logic                int1_od,
  input  logic                int2_od,
  input  logic                int1_as_input,
  input  logic                int1_pad_i,
  input  logic                boot_busy,
  input  logic                fifo_ovr,
  input  logic                fifo_full,
  input  logic                fifo_fth,
  output logic [7:0]          status,
  output logic [NAXES*DW-1:0] out_word,
  output logic                int1_o,
  output logic                int1_oe,
  output logic                int2_o,
  output logic                int2_oe,
  output logic                fifo_trig
);
  localparam int PULSE_W = (ODR_CYC / 4 < 1) ? 1 : ODR_CYC / 4;
  localparam int PCW     = $clog2(PULSE_W + 1);

  logic [NAXES-1:0] rdy, ovr;
  stat_t            st;
  logic             rdy_shaped;

  logic [NSRC-1:0]  pin_flags [NPINS];
  logic [NSRC-1:0]  pin_en    [NPINS];
  logic [NPINS-1:0] pin_od, pin_in, pin_o, pin_oe;

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    drdy_axis_hold #(.DW(DW)) u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (smp_valid[a]),
      .data   (smp_data[a*DW +: DW]),
      .rd_lo  (rd_lo[a]),
      .rd_hi  (rd_hi[a]),
      .bdu_en (bdu_en),
      .rdy    (rdy[a]),
      .ovr    (ovr[a]),
      .word   (out_word[a*DW +: DW])
    );
  end

  always_comb begin
    st.rdy     = rdy;
    st.ovr     = ovr;
    st.rdy_all = &rdy;
    st.ovr_any = |ovr;
  end
  assign status = st;

  drdy_shaper #(.PW(PULSE_W), .CW(PCW)) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (st.rdy_all),
    .pulse_sel (drdy_pulse_sel),
    .shaped    (rdy_shaped)
  );

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      pin_flags[p]           = '0;
      pin_flags[p][SRC_BOOT] = boot_busy;
      pin_flags[p][SRC_OVR]  = fifo_ovr;
      pin_flags[p][SRC_FULL] = fifo_full;
      pin_flags[p][SRC_FTH]  = fifo_fth;
    end
    pin_flags[0][SRC_RDY] = rdy_shaped;
    pin_flags[1][SRC_RDY] = st.rdy_all;
  end

  assign pin_en[0] = int1_en;
  assign pin_en[1] = int2_en;
  assign pin_od    = {int2_od, int1_od};
  assign pin_in    = {1'b0, int1_as_input};

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    drdy_irq_pin u_pin (
      .flags    (pin_flags[p]),
      .en       (pin_en[p]),
      .od       (pin_od[p]),
      .as_input (pin_in[p]),
      .pin_o    (pin_o[p]),
      .pin_oe   (pin_oe[p])
    );
  end

  assign int1_o    = pin_o[0];
  assign int1_oe   = pin_oe[0];
  assign int2_o    = pin_o[1];
  assign int2_oe   = pin_oe[1];
  assign fifo_trig = int1_as_input & int1_pad_i;
endmodule

// File: rtl/drdy_irq_chk.sv
module drdy_irq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    smp_valid,
  input logic [3*DW-1:0] smp_data,
  input logic [2:0]    rd_hi,
  input logic          bdu_en,
  input logic          int1_as_input,
  input logic          int2_od,
  input logic [7:0]    status,
  input logic [3*DW-1:0] out_word,
  input logic          int1_o,
  input logic          int1_oe,
  input logic          int2_o
);
  // R3
  x_overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid[0] && status[0] && !rd_hi[0]) |=> (status[4] && status[0]));

  // R4
  x_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi[0] && !smp_valid[0]) |=> (!status[0] && !status[4]));

  // R5
  x_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bdu_en && smp_valid[0]) |=> (out_word[DW-1:0] == $past(smp_data[DW-1:0])));

  // R10
  od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int2_od |-> !int2_o);

  // R11
  pin1_input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int1_as_input |-> (!int1_oe && !int1_o));

  // R1
  y_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid[1] |=> status[1]);
endmodule

bind drdy_irq_router drdy_irq_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .smp_valid     (smp_valid),
  .smp_data      (smp_data),
  .rd_hi         (rd_hi),
  .bdu_en        (bdu_en),
  .int1_as_input (int1_as_input),
  .int2_od       (int2_od),
  .status        (status),
  .out_word      (out_word),
  .int1_o        (int1_o),
  .int1_oe       (int1_oe),
  .int2_o        (int2_o)
);

// File: tb/sim_drdy_irq_router.sv
module sim_drdy_irq_router;
  localparam int DW = 16;
  localparam int ODR_CYC = 40;
  localparam int PW = ODR_CYC / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] smp_valid = '0;
  logic [3*DW-1:0] smp_data = '0;
  logic [2:0] rd_lo = '0, rd_hi = '0;
  logic bdu_en = 1'b0, drdy_pulse_sel = 1'b0;
  logic [4:0] int1_en = '0, int2_en = '0;
  logic int1_od = 1'b0, int2_od = 1'b0, int1_as_input = 1'b0, int1_pad_i = 1'b0;
  logic boot_busy = 1'b0, fifo_ovr = 1'b0, fifo_full = 1'b0, fifo_fth = 1'b0;
  logic [7:0] status;
  logic [3*DW-1:0] out_word;
  logic int1_o, int1_oe, int2_o, int2_oe, fifo_trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  drdy_irq_router #(.DW(DW), .ODR_CYC(ODR_CYC)) u0 (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] m, input logic [DW-1:0] x, y, z);
    @(negedge clk);
    smp_valid = m;
    smp_data  = {z, y, x};
    @(posedge clk);
    @(negedge clk);
    smp_valid = '0;
  endtask

  task automatic rd(input logic [2:0] lo, input logic [2:0] hi);
    @(negedge clk);
    rd_lo = lo;
    rd_hi = hi;
    @(posedge clk);
    @(negedge clk);
    rd_lo = '0;
    rd_hi = '0;
  endtask

  task automatic t_reset;
    check(status == 8'h00, "R13 status", status, 0);
    check(out_word == '0, "R13 words", out_word, 0);
    check(int1_oe && !int1_o, "R13 pin1 idle", {int1_oe, int1_o}, 2'b10);
  endtask

  task automatic t_ready;
    send(3'b001, 16'h0011, 0, 0);
    check(status == 8'h01, "R1 x ready only", status, 8'h01);
    send(3'b110, 0, 16'h0022, 16'h0033);
    check(status == 8'h0F, "R2 all ready", status, 8'h0F);
  endtask

  task automatic t_overrun;
    send(3'b001, 16'h0044, 0, 0);
    check(status == 8'h9F, "R3 x overrun", status, 8'h9F);
  endtask

  task automatic t_clear;
    rd(3'b000, 3'b001);
    check(status == 8'h06, "R4 x cleared", status, 8'h06);
    rd(3'b000, 3'b110);
    check(status == 8'h00, "R4 all cleared", status, 8'h00);
  endtask

  task automatic t_nobdu;
    bdu_en = 1'b0;
    send(3'b001, 16'h1234, 0, 0);
    check(out_word[15:0] == 16'h1234, "R5 first", out_word[15:0], 16'h1234);
    send(3'b001, 16'h5678, 0, 0);
    check(out_word[15:0] == 16'h5678, "R5 second", out_word[15:0], 16'h5678);
    rd(3'b111, 3'b111);
  endtask

  task automatic t_bdu;
    bdu_en = 1'b1;
    send(3'b001, 16'hA001, 0, 0);
    check(out_word[15:0] == 16'hA001, "R6 load when free", out_word[15:0], 16'hA001);
    send(3'b001, 16'hB002, 0, 0);
    check(out_word[15:0] == 16'hA001, "R6 held", out_word[15:0], 16'hA001);
    send(3'b001, 16'hC003, 0, 0);
    rd(3'b001, 3'b000);
    check(out_word[15:0] == 16'hA001, "R6 held after low read", out_word[15:0], 16'hA001);
    rd(3'b000, 3'b001);
    check(out_word[15:0] == 16'hC003, "R6 newest loaded", out_word[15:0], 16'hC003);
    rd(3'b111, 3'b111);
    bdu_en = 1'b0;
  endtask

  task automatic t_latched;
    drdy_pulse_sel = 1'b0;
    int1_en = 5'b00001;
    send(3'b111, 1, 2, 3);
    check(int1_o == 1'b1, "R7 level high", int1_o, 1);
    rd(3'b000, 3'b001);
    check(int1_o == 1'b0, "R7 level low", int1_o, 0);
    rd(3'b000, 3'b111);
    repeat (PW + 2) @(negedge clk);
  endtask

  task automatic t_pulse;
    int highs = 0;
    bit pin2_ok = 1'b1;
    drdy_pulse_sel = 1'b1;
    int1_en = 5'b00001;
    int2_en = 5'b00001;
    send(3'b111, 4, 5, 6);
    check(int1_o == 1'b0, "R8 not yet", int1_o, 0);
    for (int i = 0; i < 3 * PW; i++) begin
      @(negedge clk);
      if (int1_o) highs++;
      if (!int2_o) pin2_ok = 1'b0;
    end
    check(highs == PW, "R8 pulse width", highs, PW);
    check(pin2_ok, "R12 pin2 level", pin2_ok, 1);
    rd(3'b000, 3'b111);
    drdy_pulse_sel = 1'b0;
    int2_en = '0;
  endtask

  task automatic t_route;
    int1_en = 5'b00010; boot_busy = 1'b1; #1;
    check(int1_o == 1'b1, "R9 boot", int1_o, 1);
    int1_en = 5'b11101; #1;
    check(int1_o == 1'b0, "R9 boot masked", int1_o, 0);
    boot_busy = 1'b0;
    int1_en = 5'b00100; fifo_ovr = 1'b1; #1;
    check(int1_o == 1'b1, "R9 overrun", int1_o, 1);
    fifo_ovr = 1'b0;
    int1_en = 5'b01000; fifo_full = 1'b1; #1;
    check(int1_o == 1'b1, "R9 full", int1_o, 1);
    int1_en = 5'b10000; #1;
    check(int1_o == 1'b0, "R9 full masked", int1_o, 0);
    fifo_full = 1'b0; fifo_fth = 1'b1; #1;
    check(int1_o == 1'b1, "R9 threshold", int1_o, 1);
    fifo_fth = 1'b0; int1_en = '0;
  endtask

  task automatic t_od;
    int2_od = 1'b1; int2_en = 5'b00010; boot_busy = 1'b1; #1;
    check(!int2_o && int2_oe, "R10 od pull", {int2_o, int2_oe}, 2'b01);
    boot_busy = 1'b0; #1;
    check(!int2_o && !int2_oe, "R10 od release", {int2_o, int2_oe}, 2'b00);
    int2_od = 1'b0; boot_busy = 1'b1; #1;
    check(int2_o && int2_oe, "R10 push-pull", {int2_o, int2_oe}, 2'b11);
    boot_busy = 1'b0; int2_en = '0;
  endtask

  task automatic t_input;
    int1_as_input = 1'b1; int1_en = 5'b00010; boot_busy = 1'b1; int1_pad_i = 1'b1; #1;
    check(!int1_oe && !int1_o, "R11 no drive", {int1_oe, int1_o}, 0);
    check(fifo_trig == 1'b1, "R11 trigger passes", fifo_trig, 1);
    int1_as_input = 1'b0; #1;
    check(fifo_trig == 1'b0, "R11 trigger gated", fifo_trig, 0);
    boot_busy = 1'b0; int1_pad_i = 1'b0; int1_en = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ready();
    t_overrun();
    t_clear();
    t_nobdu();
    t_bdu();
    t_latched();
    t_pulse();
    t_route();
    t_od();
    t_input();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule